// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single channel of a four-channel counter/timer peripheral, together with its processor register port. The processor writes bytes through an 8-bit port. A byte with bit 0 set is a control word that sets the mode. When the control word announces it, the next byte is a time constant that loads the channel's 8-bit down-counter and the reload register.

In counter mode, each selected edge of the external trigger input takes one from the count. In timer mode the count steps on a system clock divided by 16 or by 256. It starts either as soon as the time constant is loaded or on the first selected trigger edge. When the count reaches zero, the channel reloads from the time constant, emits a one-cycle zero-count pulse and, if interrupts are enabled, sets a pending interrupt flag. A separate acknowledge input clears that flag. Vector generation and daisy-chain priority sit in another block. A build-time parameter removes the zero-count pin for the channel that has none.

Top module: `ctc_channel`

## Requirements
- R1: A write is the cycle in which `ce_n` and `iorq_n` are both low and `rd_n` is high. It is taken once per such assertion. A byte with bit 0 = 1 is a control word, with these bits: 7 interrupt enable, 6 counter mode (0 = timer), 5 divide by 256 (0 = by 16), 4 rising trigger edge (0 = falling), 3 timer waits for a trigger, 2 a time constant follows, 1 stop. When bit 2 is set, the next write loads both the time constant and the count.
- R2: While `ce_n`, `iorq_n` and `rd_n` are all low, `dout` shows the current count. Otherwise `dout` is 0.
- R3: In counter mode, each selected edge of `trg` lowers the count by one, 3 clocks after the edge reaches the pin. An edge of the other polarity does nothing.
- R4: In timer mode without trigger wait, counting starts when the time constant is loaded, with one decrement every 16 or every 256 clocks.
- R5: In timer mode with trigger wait, the count holds until a selected `trg` edge. The first decrement comes 16 (or 256) clocks after that edge is seen.
- R6: A time constant of 0 counts as 256: the count reads 0, then 255 after one decrement, and it reaches zero after 256 decrements.
- R7: When a decrement reaches zero, the count reloads from the time constant and `zc` is high for exactly one clock.
- R8: When interrupts are enabled, reaching zero sets `irq`. `irq_ack` clears it on the next edge unless a new zero arrives in the same cycle. A control word with bit 7 = 0 also clears it.
- R9: A control word with bit 1 set stops counting. The count holds until a new time constant is written.
- R10: After reset the count is 0, the channel is stopped, interrupts are disabled and `zc` and `irq` are low.
- R11: With `HAS_ZC` = 0, `zc` stays low at all times. Everything else behaves the same.
- R12: A byte with bit 0 = 0, written when no time constant is expected, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Channel select, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low; high during a write |
| irq_ack | input | 1 | Clears the pending interrupt flag |
| din | input | 8 | Write data |
| trg | input | 1 | External clock / trigger, asynchronous |
| dout | output | 8 | Read data (count during a read, else 0) |
| zc | output | 1 | One-cycle zero-count pulse |
| irq | output | 1 | Pending interrupt flag |

## Verification
A wrong count value reaches the ports in two ways: at once on the next read, or at the next zero crossing, where `zc` and `irq` fire early or late. A slip in the prescaler phase or in the trigger-start state stays hidden until that zero. So the bench measures the exact clock of the first pulse from a known start. A bad pending flag shows on `irq` in the cycle after the event that should have changed it.

// File: rtl/ctc_channel.sv
module ctc_channel #(
  parameter int HAS_ZC = 1,
  parameter int W      = 8,
  parameter int LO_SH  = 4,
  parameter int HI_SH  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         iorq_n,
  input  logic         rd_n,
  input  logic         irq_ack,
  input  logic [W-1:0] din,
  input  logic         trg,
  output logic [W-1:0] dout,
  output logic         zc,
  output logic         irq
);
  localparam int B_IEN  = 7;
  localparam int B_CNT  = 6;
  localparam int B_BIG  = 5;
  localparam int B_RISE = 4;
  localparam int B_TRIG = 3;
  localparam int B_TC   = 2;
  localparam int B_STOP = 1;
  localparam logic [W-1:0] ONE = W'(1);

  logic             wr_q, ien, cmode, big, rise, tstart, expect_tc, run, armed, zc_q, pend;
  logic [2:0]       sy;
  logic [HI_SH-1:0] pre;
  logic [W-1:0]     cnt, tc;

  wire wr_act = ~ce_n & ~iorq_n & rd_n;
  wire rd_act = ~ce_n & ~iorq_n & ~rd_n;
  wire wr_stb = wr_act & ~wr_q;
  wire edge_s = rise ? (sy[1] & ~sy[2]) : (~sy[1] & sy[2]);
  wire tick   = big ? &pre[HI_SH-1:0] : &pre[LO_SH-1:0];
  wire dec    = run & (cmode ? edge_s : tick);

  assign dout = rd_act ? cnt : '0;
  assign irq  = pend;

  generate
    if (HAS_ZC != 0) begin : g_zc
      assign zc = zc_q;
    end else begin : g_nozc
      assign zc = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; sy <= '0; pre <= '0; cnt <= '0; tc <= '0;
      ien <= 1'b0; cmode <= 1'b0; big <= 1'b0; rise <= 1'b0; tstart <= 1'b0;
      expect_tc <= 1'b0; run <= 1'b0; armed <= 1'b0; zc_q <= 1'b0; pend <= 1'b0;
    end else begin
      wr_q <= wr_act;
      sy   <= {sy[1:0], trg};
      zc_q <= 1'b0;
      if (run & ~cmode) pre <= pre + 1'b1;
      if (irq_ack) pend <= 1'b0;
      if (wr_stb) begin
        if (expect_tc) begin
          expect_tc <= 1'b0;
          tc  <= din;
          cnt <= din;
          pre <= '0;
          if (!cmode && tstart) begin
            run <= 1'b0; armed <= 1'b1;
          end else begin
            run <= 1'b1; armed <= 1'b0;
          end
        end else if (din[0]) begin
          ien       <= din[B_IEN];
          cmode     <= din[B_CNT];
          big       <= din[B_BIG];
          rise      <= din[B_RISE];
          tstart    <= din[B_TRIG];
          expect_tc <= din[B_TC];
          if (!din[B_IEN]) pend <= 1'b0;
          if (din[B_STOP]) begin
            run <= 1'b0; armed <= 1'b0;
          end
        end
      end else if (armed && edge_s) begin
        armed <= 1'b0;
        run   <= 1'b1;
        pre   <= '0;
      end else if (dec) begin
        if (cnt == ONE) begin
          cnt  <= tc;
          zc_q <= 1'b1;
          if (ien) pend <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

module ctc_channel_chk #(
  parameter int HAS_ZC = 1,
  parameter int W      = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ce_n,
  input logic         iorq_n,
  input logic         rd_n,
  input logic         irq_ack,
  input logic [W-1:0] dout,
  input logic         zc,
  input logic         irq
);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!zc && !irq));
  // R2
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !iorq_n && !rd_n) |-> (dout == '0));
  generate
    if (HAS_ZC != 0) begin : g_zc
      // R7
      zc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zc |=> !zc);
      // R8
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!irq || zc));
      // R8
      irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> zc);
    end else begin : g_nozc
      // R11
      no_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zc);
    end
  endgenerate
endmodule

bind ctc_channel ctc_channel_chk #(.HAS_ZC(HAS_ZC), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
  .irq_ack(irq_ack), .dout(dout), .zc(zc), .irq(irq)
);

// File: tb/sim_ctc_channel.sv
`timescale 1ns/1ps
module sim_ctc_channel;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1;
  logic irq_ack = 1'b0, trg = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, dout1;
  logic zc, irq, zc1, irq1;
  int vec = 0, bad = 0, zc_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctc_channel u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .irq_ack(irq_ack), .din(din), .trg(trg), .dout(dout), .zc(zc), .irq(irq));
  ctc_channel #(.HAS_ZC(0)) u1 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .irq_ack(irq_ack), .din(din), .trg(trg), .dout(dout1), .zc(zc1), .irq(irq1));

  // behavioural reference
  int m_cnt, m_tc, m_pre, a1, a2, a3;
  bit m_ien, m_cm, m_big, m_rise, m_ts, m_exp, m_run, m_arm, m_zc, m_pend, m_wq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tc = 0; m_pre = 0; a1 = 0; a2 = 0; a3 = 0;
      {m_ien, m_cm, m_big, m_rise, m_ts, m_exp, m_run, m_arm, m_zc, m_pend, m_wq} = '0;
    end else begin
      automatic bit wr = !ce_n && !iorq_n && rd_n;
      automatic bit stb = wr && !m_wq;
      automatic bit e = m_rise ? (a2 == 1 && a3 == 0) : (a2 == 0 && a3 == 1);
      automatic int per = m_big ? 256 : 16;
      automatic bit tk = 0;
      m_wq = wr;
      a3 = a2; a2 = a1; a1 = int'(trg);
      m_zc = 0;
      if (m_run && !m_cm) begin
        tk = ((m_pre % per) == per - 1);
        m_pre = (m_pre + 1) % 256;
      end
      if (irq_ack) m_pend = 0;
      if (stb) begin
        if (m_exp) begin
          m_exp = 0; m_tc = din; m_cnt = din; m_pre = 0;
          if (!m_cm && m_ts) begin m_run = 0; m_arm = 1; end
          else begin m_run = 1; m_arm = 0; end
        end else if (din[0]) begin
          m_ien = din[7]; m_cm = din[6]; m_big = din[5]; m_rise = din[4];
          m_ts = din[3]; m_exp = din[2];
          if (!din[7]) m_pend = 0;
          if (din[1]) begin m_run = 0; m_arm = 0; end
        end
      end else if (m_arm && e) begin
        m_arm = 0; m_run = 1; m_pre = 0;
      end else if (m_run && (m_cm ? e : tk)) begin
        if (m_cnt == 1) begin
          m_cnt = m_tc; m_zc = 1;
          if (m_ien) m_pend = 1;
        end else m_cnt = (m_cnt + 255) % 256;
      end
    end
  end

  task automatic fail_msg(input string tag, input int act, input int exp);
    bad++;
    $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int ed = (!ce_n && !iorq_n && !rd_n) ? m_cnt : 0;
      vec++;
      if (dout !== 8'(ed))  fail_msg("R2 dout", dout, ed);
      if (dout1 !== 8'(ed)) fail_msg("R2 dout u1", dout1, ed);
      if (zc !== m_zc)      fail_msg("R7 zc", zc, m_zc);
      if (irq !== m_pend)   fail_msg("R8 irq", irq, m_pend);
      if (irq1 !== m_pend)  fail_msg("R8 irq u1", irq1, m_pend);
      if (zc1 !== 1'b0)     fail_msg("R11 zc u1", zc1, 0);
      if (zc) zc_cnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) fail_msg(tag, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1; ce_n = 0; iorq_n = 0; rd_n = 1; din = d;
    @(posedge clk); #1; ce_n = 1; iorq_n = 1; din = 0;
  endtask

  task automatic rd(input int exp, input string tag);
    @(posedge clk); #1; ce_n = 0; iorq_n = 0; rd_n = 0;
    @(negedge clk); chk(tag, dout, exp);
    @(posedge clk); #1; ce_n = 1; iorq_n = 1; rd_n = 1;
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      @(posedge clk); #1; trg = 1;
      @(posedge clk); #1; trg = 0;
    end
    cyc(4);
  endtask

  task automatic until_zc(output int k, input int lim);
    k = 0;
    while (k < lim) begin
      @(negedge clk); k++;
      if (zc) break;
    end
  endtask

  initial begin
    #1200000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int k;
    cyc(3); rst_n = 1; cyc(2);
    // R10
    rd(0, "R10 count after reset");
    chk("R10 irq after reset", irq, 0);
    chk("R10 zc after reset", zc, 0);

    // R1 R3 R7 R8: counter, rising, ien, tc 3
    wr(8'hD5); wr(8'd3);
    rd(3, "R1 time constant load");
    pulse(2);
    rd(1, "R3 rising edges");
    zc_cnt = 0;
    pulse(1);
    chk("R7 one pulse on zero", zc_cnt, 1);
    rd(3, "R7 reload");
    chk("R8 irq set", irq, 1);
    @(posedge clk); #1; irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R8 irq cleared by ack", irq, 0);

    // R3 falling polarity, R12 ignored writes
    wr(8'hC5); wr(8'd2);
    trg = 1; cyc(5);
    rd(2, "R3 wrong polarity ignored");
    trg = 0; cyc(5);
    rd(1, "R3 falling edge");
    wr(8'h40); wr(8'h00);
    rd(1, "R12 plain byte ignored");
    pulse(1);
    chk("R8 irq set again", irq, 1);
    wr(8'h41);
    cyc(1);
    chk("R8 disable clears irq", irq, 0);

    // R4 timer /16 and /256
    wr(8'h85); wr(8'd2);
    until_zc(k, 100);
    chk("R4 divide by 16 timing", k, 33);
    wr(8'hA5); wr(8'd1);
    until_zc(k, 600);
    chk("R4 divide by 256 timing", k, 257);
    @(posedge clk); #1; irq_ack = 1; cyc(1); irq_ack = 0;

    // R5 trigger start
    wr(8'h9D); wr(8'd1);
    zc_cnt = 0; cyc(40);
    chk("R5 held before trigger", zc_cnt, 0);
    rd(1, "R5 count held");
    cyc(1); trg = 1;
    until_zc(k, 100);
    chk("R5 start from trigger", k, 20);
    trg = 0; cyc(3);

    // R6 time constant 0
    wr(8'h55); wr(8'd0);
    rd(0, "R6 zero loaded");
    pulse(1);
    rd(255, "R6 wraps to 255");
    zc_cnt = 0;
    pulse(254);
    chk("R6 no zero before 256", zc_cnt, 0);
    rd(1, "R6 count one");
    pulse(1);
    chk("R6 zero after 256", zc_cnt, 1);
    rd(0, "R6 reload to 0");

    // R9 stop
    wr(8'h53);
    pulse(3);
    rd(0, "R9 stopped");
    wr(8'h55); wr(8'd5);
    pulse(2);
    rd(3, "R9 restart after time constant");

    cyc(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule